// File: doc/BRIEF.md
# Minimum-Cost Switching-State Selector with Gate Drive

This block closes the decision step of a finite-set predictive current controller for a two-level three-phase inverter. Once per sample period it takes eight candidate costs, each paired with the 3-bit switching state it was computed for. It picks the candidate with the smallest cost and drives the six power switches from the winning state. The costs are reduced by a linear chain of compare-and-keep stages, one register per stage. Each stage's one-bit decision steers both the running cost and a parallel running switching state, so the state always stays paired with the cost that won.

The chain ends in an output register. It holds the minimum cost, an index number for observation, and the upper and lower gate signals. These outputs change only on the cycle the result leaves the pipeline, and they hold between results. A new sample may enter on every clock, so several samples can be in flight at once.

Top module: `min_state_selector`

## Requirements
- R1: On each result, `min_cost` equals the smallest of the eight costs that entered together with the matching `in_valid`. Costs are unsigned; candidate j occupies `cost_bus[j*COST_W +: COST_W]`.
- R2: The reported state is the 3-bit state supplied at the same position as the winning cost. Candidate j's state occupies `state_bus[3*j +: 3]`.
- R3: `out_valid` is a one-cycle pulse 7 clock cycles after the cycle in which `in_valid` was sampled high (N_CAND-1 stages). Samples may arrive on consecutive cycles, and each yields its own pulse in order.
- R4: `gate_hi` carries the winning state with bit 2 driving the phase-a upper switch, bit 1 phase b and bit 0 phase c. `gate_lo` is the bitwise complement for the matching lower switches.
- R5: `index_num` is the unsigned value of the winning state with bit 2 (phase a) as MSB. For example, state 100 gives index 4.
- R6: When two or more candidates share the smallest cost, the one at the lowest position wins.
- R7: While reset is asserted and until the first result, `out_valid` is 0, `min_cost` is 0, `index_num` is 0, `gate_hi` is 000 and `gate_lo` is 111.
- R8: On cycles without `out_valid`, `min_cost`, `index_num`, `gate_hi` and `gate_lo` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A new set of candidates is present this cycle |
| cost_bus | input | N_CAND*COST_W | Candidate costs, candidate j at bits j*COST_W upward |
| state_bus | input | N_CAND*3 | Candidate switching states, candidate j at bits 3*j upward |
| out_valid | output | 1 | One-cycle pulse marking a new result |
| min_cost | output | COST_W | Smallest cost of the latest result |
| index_num | output | 3 | Index number of the winning state |
| gate_hi | output | 3 | Upper switch gates, bit 2 = phase a |
| gate_lo | output | 3 | Lower switch gates, complement of gate_hi |

## Verification
The first pattern sets all costs equal. It separates a strict comparison from a non-strict one, because only a strict comparison keeps position 0. The next patterns sweep a single minimum across every position with distinct states. These show that each stage's select steers the state chain as well as the cost chain, and that no stage is skipped. Further patterns place ties at interior positions, use costs at the top and bottom of the range, and stream random vectors back to back and with gaps. These probe carry-out errors in the comparison, pipeline ordering, and holding of the outputs between results.

// File: rtl/minsel_pkg.sv
package minsel_pkg;

  localparam int SW_W = 3;

  typedef logic [SW_W-1:0] sw_state_t;

  // Upper gates: bit 2 = phase a, bit 1 = phase b, bit 0 = phase c
  function automatic logic [SW_W-1:0] upper_gates(input sw_state_t s);
    return {s[2], s[1], s[0]};
  endfunction

  // Lower switches of each leg take the complement
  function automatic logic [SW_W-1:0] lower_gates(input sw_state_t s);
    return ~upper_gates(s);
  endfunction

  // Index number: state read as unsigned binary, phase a as MSB
  function automatic logic [SW_W-1:0] state_index(input sw_state_t s);
    return (SW_W)'(unsigned'(s));
  endfunction

endpackage

// File: rtl/minsel_delay.sv
module minsel_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] tap [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
    end else begin
      tap[0] <= d;
      for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
    end
  end

  assign q = tap[DEPTH-1];

endmodule

// File: rtl/minsel_stage.sv
module minsel_stage
  import minsel_pkg::*;
#(
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [COST_W-1:0] run_cost,
  input  sw_state_t         run_state,
  input  logic [COST_W-1:0] cand_cost,
  input  sw_state_t         cand_state,
  output logic              sel,
  output logic              out_valid,
  output logic [COST_W-1:0] out_cost,
  output sw_state_t         out_state
);

  // Strict comparison: the earlier (running) candidate keeps ties
  assign sel = (cand_cost < run_cost);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cost  <= '0;
      out_state <= '0;
    end else begin
      out_valid <= in_valid;
      out_cost  <= sel ? cand_cost  : run_cost;
      out_state <= sel ? cand_state : run_state;
    end
  end

endmodule

// File: rtl/minsel_drive.sv
module minsel_drive
  import minsel_pkg::*;
#(
  parameter int COST_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fin_valid,
  input  logic [COST_W-1:0] fin_cost,
  input  sw_state_t         fin_state,
  output logic              out_valid,
  output logic [COST_W-1:0] min_cost,
  output logic [SW_W-1:0]   index_num,
  output logic [SW_W-1:0]   gate_hi,
  output logic [SW_W-1:0]   gate_lo
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      min_cost  <= '0;
      index_num <= '0;
      gate_hi   <= upper_gates('0);
      gate_lo   <= lower_gates('0);
    end else begin
      out_valid <= fin_valid;
      if (fin_valid) begin
        min_cost  <= fin_cost;
        index_num <= state_index(fin_state);
        gate_hi   <= upper_gates(fin_state);
        gate_lo   <= lower_gates(fin_state);
      end
    end
  end

endmodule

// File: rtl/min_state_selector.sv
module min_state_selector
  import minsel_pkg::*;
#(
  parameter int COST_W = 16,
  parameter int N_CAND = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [N_CAND*COST_W-1:0] cost_bus,
  input  logic [N_CAND*SW_W-1:0]   state_bus,
  output logic                     out_valid,
  output logic [COST_W-1:0]        min_cost,
  output logic [SW_W-1:0]          index_num,
  output logic [SW_W-1:0]          gate_hi,
  output logic [SW_W-1:0]          gate_lo
);

  localparam int NSTAGE = N_CAND - 1;
  localparam int PAIR_W = COST_W + SW_W;

  logic [COST_W-1:0] cost_vec  [N_CAND];
  sw_state_t         state_vec [N_CAND];

  logic              rin_valid [NSTAGE];
  logic [COST_W-1:0] rin_cost  [NSTAGE];
  sw_state_t         rin_state [NSTAGE];
  logic [COST_W-1:0] cand_cost [NSTAGE];
  sw_state_t         cand_state[NSTAGE];
  logic              st_valid  [NSTAGE];
  logic [COST_W-1:0] st_cost   [NSTAGE];
  sw_state_t         st_state  [NSTAGE];

  // Flattened views of internal events, for the checker
  logic [NSTAGE-1:0]        sel_bus;
  logic [NSTAGE-1:0]        stv_bus;
  logic [NSTAGE-1:0]        rinv_bus;
  logic [NSTAGE*COST_W-1:0] stc_bus;
  logic [NSTAGE*COST_W-1:0] rinc_bus;
  logic [NSTAGE*COST_W-1:0] candc_bus;

  for (genvar j = 0; j < N_CAND; j++) begin : g_unpack
    assign cost_vec[j]  = cost_bus[j*COST_W +: COST_W];
    assign state_vec[j] = state_bus[j*SW_W +: SW_W];
  end

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage
    if (k == 0) begin : g_head
      assign rin_valid[k]  = in_valid;
      assign rin_cost[k]   = cost_vec[0];
      assign rin_state[k]  = state_vec[0];
      assign cand_cost[k]  = cost_vec[1];
      assign cand_state[k] = state_vec[1];
    end else begin : g_body
      logic [PAIR_W-1:0] pair_d;
      assign rin_valid[k] = st_valid[k-1];
      assign rin_cost[k]  = st_cost[k-1];
      assign rin_state[k] = st_state[k-1];
      // Candidate k+1 waits k cycles to meet the running minimum
      minsel_delay #(.W(PAIR_W), .DEPTH(k)) u_dly (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cost_vec[k+1], state_vec[k+1]}),
        .q     (pair_d)
      );
      assign cand_cost[k]  = pair_d[PAIR_W-1:SW_W];
      assign cand_state[k] = pair_d[SW_W-1:0];
    end

    minsel_stage #(.COST_W(COST_W)) u_stg (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (rin_valid[k]),
      .run_cost   (rin_cost[k]),
      .run_state  (rin_state[k]),
      .cand_cost  (cand_cost[k]),
      .cand_state (cand_state[k]),
      .sel        (sel_bus[k]),
      .out_valid  (st_valid[k]),
      .out_cost   (st_cost[k]),
      .out_state  (st_state[k])
    );

    assign stv_bus[k]                     = st_valid[k];
    assign rinv_bus[k]                    = rin_valid[k];
    assign stc_bus[k*COST_W +: COST_W]    = st_cost[k];
    assign rinc_bus[k*COST_W +: COST_W]   = rin_cost[k];
    assign candc_bus[k*COST_W +: COST_W]  = cand_cost[k];
  end

  minsel_drive #(.COST_W(COST_W)) u_drv (
    .clk       (clk),
    .rst_n     (rst_n),
    .fin_valid (st_valid[NSTAGE-1]),
    .fin_cost  (st_cost[NSTAGE-1]),
    .fin_state (st_state[NSTAGE-1]),
    .out_valid (out_valid),
    .min_cost  (min_cost),
    .index_num (index_num),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo)
  );

endmodule

// File: rtl/min_state_selector_chk.sv
module min_state_selector_chk #(
  parameter int COST_W = 16,
  parameter int N_CAND = 8
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         out_valid,
  input logic [COST_W-1:0]            min_cost,
  input logic [2:0]                   index_num,
  input logic [2:0]                   gate_hi,
  input logic [2:0]                   gate_lo,
  input logic [N_CAND-2:0]            sel_bus,
  input logic [N_CAND-2:0]            stv_bus,
  input logic [N_CAND-2:0]            rinv_bus,
  input logic [(N_CAND-1)*COST_W-1:0] stc_bus,
  input logic [(N_CAND-1)*COST_W-1:0] rinc_bus,
  input logic [(N_CAND-1)*COST_W-1:0] candc_bus
);

  localparam int NSTAGE = N_CAND - 1;

  for (genvar k = 0; k < NSTAGE; k++) begin : g_stage_chk
    // Ties keep the earlier candidate
    p_tie_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (rinv_bus[k] && (candc_bus[k*COST_W +: COST_W] == rinc_bus[k*COST_W +: COST_W]))
        |-> !sel_bus[k]);

    if (k < NSTAGE - 1) begin : g_link
      p_chain_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        stv_bus[k] |=> stv_bus[k+1]);
      // The running minimum never grows along the chain
      p_nonincr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stv_bus[k] |=> (stc_bus[(k+1)*COST_W +: COST_W] <= $past(stc_bus[k*COST_W +: COST_W])));
    end
  end

  p_out_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    stv_bus[NSTAGE-1] |=> out_valid);

  p_out_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !stv_bus[NSTAGE-1] |=> !out_valid);

  p_gate_compl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    gate_lo == ~gate_hi);

  p_index_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    index_num == gate_hi);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable({min_cost, index_num, gate_hi, gate_lo}));

endmodule

bind min_state_selector min_state_selector_chk #(
  .COST_W (COST_W),
  .N_CAND (N_CAND)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .out_valid (out_valid),
  .min_cost  (min_cost),
  .index_num (index_num),
  .gate_hi   (gate_hi),
  .gate_lo   (gate_lo),
  .sel_bus   (sel_bus),
  .stv_bus   (stv_bus),
  .rinv_bus  (rinv_bus),
  .stc_bus   (stc_bus),
  .rinc_bus  (rinc_bus),
  .candc_bus (candc_bus)
);

// File: tb/sim_min_state_selector.sv
module sim_min_state_selector;

  localparam int CLK_PERIOD = 10;
  localparam int COST_W     = 16;
  localparam int N_CAND     = 8;
  localparam int LAT        = 7;
  localparam int WATCHDOG   = 100000;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic                     in_valid = 1'b0;
  logic [N_CAND*COST_W-1:0] cost_bus = '0;
  logic [N_CAND*3-1:0]      state_bus = '0;
  logic                     out_valid;
  logic [COST_W-1:0]        min_cost;
  logic [2:0]               index_num;
  logic [2:0]               gate_hi;
  logic [2:0]               gate_lo;

  min_state_selector #(.COST_W(COST_W), .N_CAND(N_CAND)) u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .cost_bus  (cost_bus),
    .state_bus (state_bus),
    .out_valid (out_valid),
    .min_cost  (min_cost),
    .index_num (index_num),
    .gate_hi   (gate_hi),
    .gate_lo   (gate_lo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    int          due;
    logic [15:0] cost;
    logic [2:0]  st;
    bit          tied;
  } exp_t;

  exp_t        q[$];
  int          cyc = 0;
  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  logic [15:0] h_cost = '0;
  logic [2:0]  h_st = 3'b000;
  bit          h_tied = 1'b0;

  int c_arr [N_CAND];
  int s_arr [N_CAND];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model: record each accepted sample with its due cycle
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && in_valid) begin
      exp_t e;
      int   best;
      int   cnt;
      best = 0;
      for (int j = 1; j < N_CAND; j++)
        if (c_arr[j] < c_arr[best]) best = j;
      cnt = 0;
      for (int j = 0; j < N_CAND; j++)
        if (c_arr[j] == c_arr[best]) cnt++;
      e.due  = cyc + 1 + LAT;
      e.cost = 16'(c_arr[best]);
      e.st   = 3'(s_arr[best]);
      e.tied = (cnt > 1);
      q.push_back(e);
    end
  end

  // Compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit ev;
      ev = (q.size() > 0) && (q[0].due == cyc);
      chk(out_valid == ev, "R3", "out_valid", out_valid, ev);
      if (ev) begin
        h_cost = q[0].cost;
        h_st   = q[0].st;
        h_tied = q[0].tied;
        void'(q.pop_front());
        chk(min_cost == h_cost, h_tied ? "R6" : "R1", "min_cost", min_cost, h_cost);
        chk(gate_hi == h_st, "R2", "winning state on gate_hi", gate_hi, h_st);
        chk(index_num == h_st, "R5", "index_num", index_num, h_st);
        chk(gate_lo == ~h_st, "R4", "gate_lo", gate_lo, 3'(~h_st));
      end else begin
        chk(min_cost == h_cost, "R8", "min_cost held", min_cost, h_cost);
        chk(index_num == h_st, "R8", "index_num held", index_num, h_st);
        chk(gate_hi == h_st, "R8", "gate_hi held", gate_hi, h_st);
        chk(gate_lo == ~h_st, "R8", "gate_lo held", gate_lo, 3'(~h_st));
      end
    end
  end

  task automatic drive_one();
    for (int j = 0; j < N_CAND; j++) begin
      cost_bus[j*COST_W +: COST_W] = 16'(c_arr[j]);
      state_bus[j*3 +: 3]          = 3'(s_arr[j]);
    end
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    for (int j = 0; j < N_CAND; j++) begin c_arr[j] = 0; s_arr[j] = 0; end
    repeat (3) @(negedge clk);
    // R7: reset values
    chk(out_valid == 1'b0, "R7", "out_valid in reset", out_valid, 0);
    chk(min_cost == '0, "R7", "min_cost in reset", min_cost, 0);
    chk(index_num == 3'd0, "R7", "index_num in reset", index_num, 0);
    chk(gate_hi == 3'b000, "R7", "gate_hi in reset", gate_hi, 0);
    chk(gate_lo == 3'b111, "R7", "gate_lo in reset", gate_lo, 7);
    rst_n = 1'b1;
    idle(3);

    // R6: all costs equal, position 0 must win
    for (int j = 0; j < N_CAND; j++) begin c_arr[j] = 100; s_arr[j] = 7 - j; end
    drive_one();
    idle(10);

    // R1 R2: a single minimum swept over every position, back to back
    for (int p = 0; p < N_CAND; p++) begin
      for (int j = 0; j < N_CAND; j++) begin
        c_arr[j] = (j == p) ? 5 : 1000 + j * 10;
        s_arr[j] = (j + p) % 8;
      end
      drive_one();
    end
    idle(10);

    // R5: state 100 wins, index must read 4
    for (int j = 0; j < N_CAND; j++) begin c_arr[j] = 300 - j; s_arr[j] = 1; end
    s_arr[7] = 4;
    drive_one();
    idle(9);
    chk(index_num == 3'd4, "R5", "index for state 100", index_num, 4);

    // R6: interior tie between positions 3 and 6
    for (int j = 0; j < N_CAND; j++) begin c_arr[j] = 50 + j; s_arr[j] = j; end
    c_arr[3] = 2; c_arr[6] = 2;
    drive_one();
    // range edges: near-full costs, then a zero at the last position
    for (int j = 0; j < N_CAND; j++) begin c_arr[j] = 16'hFFFF; s_arr[j] = 7 - j; end
    c_arr[5] = 16'hFFFE;
    drive_one();
    for (int j = 0; j < N_CAND; j++) begin c_arr[j] = 16'h8000 + j; s_arr[j] = j ^ 5; end
    c_arr[7] = 0;
    drive_one();
    idle(12);

    // Random streams with random gaps
    for (int n = 0; n < 60; n++) begin
      for (int j = 0; j < N_CAND; j++) begin
        c_arr[j] = int'($urandom_range(0, (n % 3 == 0) ? 7 : 65535));
        s_arr[j] = int'($urandom_range(0, 7));
      end
      drive_one();
      if (n % 4 == 3) idle(int'($urandom_range(0, 9)));
    end
    idle(20);
    chk(q.size() == 0, "R3", "results left pending", q.size(), 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL R3 watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
      finish_run();
    end
  end

endmodule